// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low-Power-Idle Controller

This block decides when the transmit side of an Ethernet MAC may put the link into low-power idle (LPI) and when it must leave it. Software enables LPI and automatic transmit entry, and reports that the PHY link is up. The block then waits until the link has been up for a programmable number of milliseconds. If nothing is waiting to be sent at that point, it raises `tx_lpi_assert` towards the PHY. When a frame becomes pending, or software withdraws permission, the block drops `tx_lpi_assert` and holds transmission off for a programmable number of microseconds while the far end wakes up.

The block also watches a receive-side LPI indication. Entries into and exits from LPI on both paths are recorded as sticky event flags. The flags clear when software reads the control/status register, and their OR drives a maskable interrupt. Time comes from a one-microsecond tick input. A millisecond is counted as `US_PER_MS` of those ticks.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset `tx_lpi_assert`, `tx_hold` and `lpi_irq` are low and every register reads as zero.
- R2: Address 1 is the timer register: the wake time in microseconds sits in bits 15:0 and the link-stable time in milliseconds in bits 26:16. Other bits read 0. Address 0 bits 8 (LPI enable), 9 (automatic transmit entry) and 10 (link up) are writable and read back.
- R3: `tx_lpi_assert` rises only while enable, automatic entry and link-up are all set, no transmit is pending, and link-up has been set for at least the link-stable time. Each millisecond is `US_PER_MS` microsecond ticks.
- R4: Clearing link-up restarts the link-stable wait from zero.
- R5: A pending transmit while in LPI drops `tx_lpi_assert` on the next clock and raises `tx_hold`.
- R6: After leaving LPI, `tx_hold` stays high until wake-time microsecond ticks have passed, which is wake time + 1 cycles when a tick arrives every cycle.
- R7: Clearing LPI enable or automatic entry while in LPI forces an exit.
- R8: Address 0 bit 0 is set when transmit LPI is entered, and bit 1 when it is left.
- R9: Address 0 bit 2 is set on a rise of `rx_lpi_ind`, and bit 3 on a fall.
- R10: A read of address 0 returns the flags and then clears all four of them. An event in the same cycle as the read survives the clear.
- R11: `lpi_irq` is high when any flag is set and mask bit 0 at address 2 is clear.
- R12: Address 0 bit 16 shows that transmit LPI is active. Bit 17 shows the `rx_lpi_ind` level as registered one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 0 clears the flags) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tx_pending | input | 1 | Transmit data is waiting |
| rx_lpi_ind | input | 1 | Receive path is in LPI |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| tx_lpi_assert | output | 1 | Request LPI signalling to the PHY |
| tx_hold | output | 1 | Transmission must not start |
| lpi_irq | output | 1 | Masked LPI event interrupt |

## Verification
A wrong state shows up as `tx_lpi_assert` rising too soon after link-up, within one cycle of the expected millisecond boundary. It can also show as `tx_lpi_assert` still high one cycle after a pending transmit. A wake counter that is off shows as a `tx_hold` pulse whose width in cycles differs from wake time + 1. Flag errors show at the next read of address 0 and at `lpi_irq`, in the same cycle as the fault. Random receive-side toggling, interleaved with reads, places events on the very cycle of a clearing read.

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl #(
  parameter int US_PER_MS = 1000,
  parameter int TW_W      = 16,
  parameter int LS_W      = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_pending,
  input  logic        rx_lpi_ind,
  input  logic        us_tick,
  output logic        tx_lpi_assert,
  output logic        tx_hold,
  output logic        lpi_irq
);
  localparam int PRE_W = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(US_PER_MS - 1);
  localparam logic [1:0] A_CTRL = 2'd0, A_TIMER = 2'd1, A_MASK = 2'd2;

  typedef enum logic [1:0] {S_ACTIVE, S_WAIT_LINK, S_LPI, S_WAKE} lpi_state_t;

  lpi_state_t state, nxt;
  logic lpi_en, tx_auto, link_ok, irq_mask, rx_q;
  logic [TW_W-1:0]  tw, wake_cnt;
  logic [LS_W-1:0]  ls, link_ms;
  logic [PRE_W-1:0] pre;
  logic [3:0] flags, ev;

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire rd_ctrl  = reg_rd && reg_addr == A_CTRL;
  wire ms_tick  = link_ok && us_tick && pre == PRE_LAST;
  wire link_stable = link_ok && (link_ms >= ls);
  wire entry_ok = lpi_en && tx_auto && !tx_pending;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lpi_en <= 1'b0; tx_auto <= 1'b0; link_ok <= 1'b0;
      tw <= '0; ls <= '0; irq_mask <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:  {link_ok, tx_auto, lpi_en} <= reg_wdata[10:8];
        A_TIMER: begin tw <= reg_wdata[TW_W-1:0]; ls <= reg_wdata[16 +: LS_W]; end
        A_MASK:  irq_mask <= reg_wdata[0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre <= '0; link_ms <= '0;
    end else if (!link_ok) begin
      pre <= '0; link_ms <= '0;
    end else begin
      if (us_tick) pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
      if (ms_tick && link_ms != '1) link_ms <= link_ms + 1'b1;
    end

  always_comb begin
    nxt = state;
    case (state)
      S_ACTIVE:    if (entry_ok) nxt = S_WAIT_LINK;
      S_WAIT_LINK: if (!entry_ok) nxt = S_ACTIVE;
                   else if (link_stable) nxt = S_LPI;
      S_LPI:       if (!entry_ok) nxt = S_WAKE;
      S_WAKE:      if (wake_cnt >= tw) nxt = S_ACTIVE;
      default:     nxt = S_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_ACTIVE; wake_cnt <= '0;
    end else begin
      state <= nxt;
      if (state != S_WAKE) wake_cnt <= '0;
      else if (us_tick && wake_cnt != '1) wake_cnt <= wake_cnt + 1'b1;
    end

  assign ev[0] = state != S_LPI && nxt == S_LPI;
  assign ev[1] = state == S_LPI && nxt != S_LPI;
  assign ev[2] = rx_lpi_ind && !rx_q;
  assign ev[3] = !rx_lpi_ind && rx_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags <= '0; rx_q <= 1'b0;
    end else begin
      flags <= (rd_ctrl ? 4'd0 : flags) | ev;
      rx_q  <= rx_lpi_ind;
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[3:0]  = flags;
        reg_rdata[10:8] = {link_ok, tx_auto, lpi_en};
        reg_rdata[16]   = tx_lpi_assert;
        reg_rdata[17]   = rx_q;
      end
      A_TIMER: begin
        reg_rdata[TW_W-1:0]   = tw;
        reg_rdata[16 +: LS_W] = ls;
      end
      A_MASK:  reg_rdata[0] = irq_mask;
      default: ;
    endcase
  end

  assign tx_lpi_assert = state == S_LPI;
  assign tx_hold       = state == S_LPI || state == S_WAKE;
  assign lpi_irq       = |flags && !irq_mask;

  logic unused_ok;
  assign unused_ok = ^{wr_ctrl, reg_wdata};
endmodule

module eee_lpi_ctrl_chk #(
  parameter int LS_W = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_lpi_assert,
  input logic            tx_hold,
  input logic            tx_pending,
  input logic            lpi_en,
  input logic            tx_auto,
  input logic            link_ok,
  input logic [LS_W-1:0] link_ms,
  input logic [LS_W-1:0] ls,
  input logic [3:0]      flags,
  input logic [3:0]      ev,
  input logic            rd_ctrl
);
  assert_entry_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_lpi_assert) |-> $past(lpi_en && tx_auto && link_ok && link_ms >= ls));
  assert_pending_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lpi_assert && tx_pending |=> !tx_lpi_assert);
  assert_hold_after_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_lpi_assert) |-> tx_hold);
  assert_forced_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lpi_assert && !(lpi_en && tx_auto) |=> !tx_lpi_assert);
  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ctrl |=> (flags & $past(flags)) == $past(flags));
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> (flags & ~$past(ev)) == 4'd0);
endmodule

bind eee_lpi_ctrl eee_lpi_ctrl_chk #(.LS_W(LS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_lpi_assert(tx_lpi_assert), .tx_hold(tx_hold),
  .tx_pending(tx_pending), .lpi_en(lpi_en), .tx_auto(tx_auto), .link_ok(link_ok),
  .link_ms(link_ms), .ls(ls), .flags(flags), .ev(ev), .rd_ctrl(rd_ctrl)
);

// File: tb/tb_eee_lpi_ctrl.sv
module tb_eee_lpi_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_pending = 0, rx_lpi_ind = 0, us_tick = 1;
  logic tx_lpi_assert, tx_hold, lpi_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam int UPM = 10;
  localparam int LS = 2, TW = 5;

  always #5 clk = ~clk;

  eee_lpi_ctrl #(.US_PER_MS(UPM)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_pending(tx_pending),
    .rx_lpi_ind(rx_lpi_ind), .us_tick(us_tick), .tx_lpi_assert(tx_lpi_assert),
    .tx_hold(tx_hold), .lpi_irq(lpi_irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] timer_word(input int ls_v, input int tw_v);
    return ((32'(ls_v) & 32'h7FF) << 16) | (32'(tw_v) & 32'hFFFF);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_entry(input string req);
    int k = 1;
    repeat (14) @(negedge clk);
    chk(tx_lpi_assert == 0, req, 32'(tx_lpi_assert), 0);
    k = 15;
    while (!tx_lpi_assert && k < 60) begin @(negedge clk); k++; end
    chk(k >= LS*UPM && k <= LS*UPM + 2, req, k, LS*UPM + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0] exp_rx;
    logic rx_m;
    int n;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_lpi_assert && !tx_hold && !lpi_irq, "R1", {tx_lpi_assert, tx_hold, lpi_irq}, 0);
    for (int a = 0; a < 3; a++) begin
      reg_addr = 2'(a); #1;
      chk(reg_rdata == 0, "R1", reg_rdata, 0);
    end
    // R2 layout
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk(d == 32'h07FF_FFFF, "R2", d, 32'h07FF_FFFF);
    wr(1, timer_word(LS, TW));
    rd(1, d); chk(d == timer_word(LS, TW), "R2", d, timer_word(LS, TW));
    // R3 no entry without link
    wr(0, 32'h300);
    rd(0, d); chk(d[10:8] == 3'b011, "R2", d[10:8], 3'b011);
    repeat (50) @(negedge clk);
    chk(tx_lpi_assert == 0, "R3", 32'(tx_lpi_assert), 0);
    // R3 entry after link-stable wait
    wr(0, 32'h700);
    wait_entry("R3");
    rd(0, d);
    chk(d[0] == 1, "R8", d, 1);
    chk(d[16] == 1, "R12", d[16], 1);
    #1 chk(lpi_irq == 0, "R10", 32'(lpi_irq), 0);
    rd(0, d); chk(d[3:0] == 0, "R10", d[3:0], 0);
    // R5/R6 exit on pending, masked interrupt
    wr(2, 32'h1);
    @(negedge clk); tx_pending = 1;
    @(negedge clk);
    chk(tx_lpi_assert == 0 && tx_hold == 1, "R5", {tx_lpi_assert, tx_hold}, 2'b01);
    n = 0;
    while (tx_hold && n < 100) begin n++; @(negedge clk); end
    chk(n == TW + 1, "R6", n, TW + 1);
    chk(lpi_irq == 0, "R11", 32'(lpi_irq), 0);
    wr(2, 32'h0); #1;
    chk(lpi_irq == 1, "R11", 32'(lpi_irq), 1);
    rd(0, d); chk(d[1:0] == 2'b10, "R8", d[1:0], 2'b10);
    tx_pending = 0;
    n = 0;
    while (!tx_lpi_assert && n < 10) begin @(negedge clk); n++; end
    chk(n == 2, "R3", n, 2);
    // R7 forced exit
    wr(0, 32'h400);
    @(negedge clk);
    chk(tx_lpi_assert == 0, "R7", 32'(tx_lpi_assert), 0);
    repeat (50) @(negedge clk);
    chk(tx_lpi_assert == 0 && tx_hold == 0, "R7", {tx_lpi_assert, tx_hold}, 0);
    // R4 restart of link-stable wait
    wr(0, 32'h300);
    wr(0, 32'h700);
    wait_entry("R4");
    wr(0, 32'h000);
    repeat (20) @(negedge clk);
    rd(0, d);
    rd(0, d); chk(d[3:0] == 0 && !lpi_irq, "R10", d[3:0], 0);
    // R9/R10/R12 random receive events with reads
    exp_rx = 0; rx_m = 0;
    for (int i = 0; i < 300; i++) begin
      logic nrx, drd;
      @(negedge clk);
      nrx = ($urandom % 4 == 0) ? ~rx_m : rx_m;
      drd = ($urandom % 3 == 0);
      rx_lpi_ind = nrx; reg_rd = drd; reg_addr = 0;
      #1;
      if (drd) begin
        chk(reg_rdata[3:0] == exp_rx, "R9", reg_rdata[3:0], exp_rx);
        chk(reg_rdata[17] == rx_m, "R12", reg_rdata[17], rx_m);
        chk(lpi_irq == |exp_rx, "R11", 32'(lpi_irq), 32'(|exp_rx));
      end
      exp_rx = (drd ? 4'd0 : exp_rx) | {(!nrx && rx_m), (nrx && !rx_m), 2'b00};
      rx_m = nrx;
    end
    // R10 set wins over clearing read
    @(negedge clk); reg_rd = 1; reg_addr = 0; rx_lpi_ind = ~rx_m;
    @(negedge clk); reg_rd = 0;
    #1 d = reg_rdata;
    chk(d[3:2] == (rx_m ? 2'b10 : 2'b01), "R10", d[3:2], rx_m ? 2'b10 : 2'b01);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule